// File: doc/BRIEF.md
# Programmable Flag I/O Port

This block is a general-purpose flag port of `NPINS` pins (16 by default) with a simple register interface. Software decides, pin by pin, whether the pin drives out or is sampled. Each pin owns one flag bit. Software raises a flag through a set register and drops it through a clear register. Neither register can overwrite bits that it is not aimed at. On input pins, the flag is also raised by hardware. The input is first synchronized to the system clock. Then it is inverted or not, according to a per-pin polarity bit. Finally it is judged by level, by its active edge, or by either edge.

The flags feed two interrupt lines, A and B. Each line has its own mask, and each mask is also written only through a set/clear register pair. An interrupt line is high while any flag is high whose bit is enabled in that line's mask. Reads are combinational from a separate read address. Each set/clear pair reads back the state it controls.

Top module: `flag_port`

## Requirements
- R1: After reset every readable register returns 0, `pin_oe` is 0 and both interrupt lines are low. All pins are then level-sensitive, non-inverted inputs with both masks closed.
- R2: The address map is: 0 direction, 1 direction (alias), 2 flag clear, 3 flag set, 4 mask A clear, 5 mask A set, 6 mask B clear, 7 mask B set, 8 polarity, 9 sensitivity (1 = edge), 10 any-edge enable. Reading 2 or 3 returns the flag state, 4 or 5 returns mask A, and 6 or 7 returns mask B. Reading 0, 1, 8, 9 or 10 returns the stored register, and any other address reads 0.
- R3: A direction bit of 1 makes the pin an output (`pin_oe` high) and 0 makes it an input. Writes to address 0 and address 1 update the same register.
- R4: In a write to the set or clear register, a 1 bit sets or clears that flag and a 0 bit leaves it unchanged. The new value shows from the clock edge that takes the write. Output pins drive their flag on `pin_out`.
- R5: The clear register clears flags of input pins as well as output pins, provided no detection is active on that pin.
- R6: The level of `pin_in` on an output pin never changes its flag.
- R7: Each input passes through two synchronizing flip-flops. A level change on `pin_in` reaches the flag at the third rising clock edge after it is applied.
- R8: In level mode (sensitivity 0), the flag is set on every cycle in which the adjusted input (synchronized pin XOR polarity) is 1. A clear write therefore does not hold while the input stays active. The flag stays set after the input goes inactive, until it is cleared.
- R9: In edge mode (sensitivity 1, any-edge 0), only a 0-to-1 transition of the adjusted input sets the flag. With polarity 1, that is a falling pin.
- R10: In any-edge mode (sensitivity 1, any-edge 1), both transitions of the adjusted input set the flag.
- R11: In level mode, a one-cycle high pulse on a pin that rests low is caught with polarity 0. A one-cycle low pulse on a pin that rests high is caught with polarity 1.
- R12: `irq_a` is high exactly when some flag is set whose mask A bit is set, and `irq_b` is the same with mask B. The two masks are independent. A raised interrupt line falls only after a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write register address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | AW | Read register address |
| rd_data | output | NPINS | Combinational read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Pin output values (flag state) |
| pin_oe | output | NPINS | Pin output enables (direction) |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bench builds the port with `NPINS` = 4 and the default address width. This makes the space of flag patterns, clear patterns and mask patterns small enough to sweep completely: all 256 set/clear pairs and all 256 flag/mask pairs are tried, and every expected value is worked out arithmetically. The same narrow width lets each edge test drive every subset of pins at once. The synchronizer latency, the polarity behaviour of narrow pulses and the difference between level, edge and any-edge modes are each checked cycle by cycle.

// File: rtl/flag_port.sv
module flag_port #(
  parameter int NPINS = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NPINS-1:0] rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_a,
  output logic             irq_b
);

  localparam logic [AW-1:0] A_DIR   = AW'(0);
  localparam logic [AW-1:0] A_DIR2  = AW'(1);
  localparam logic [AW-1:0] A_FCLR  = AW'(2);
  localparam logic [AW-1:0] A_FSET  = AW'(3);
  localparam logic [AW-1:0] A_MACLR = AW'(4);
  localparam logic [AW-1:0] A_MASET = AW'(5);
  localparam logic [AW-1:0] A_MBCLR = AW'(6);
  localparam logic [AW-1:0] A_MBSET = AW'(7);
  localparam logic [AW-1:0] A_POL   = AW'(8);
  localparam logic [AW-1:0] A_SENS  = AW'(9);
  localparam logic [AW-1:0] A_ANY   = AW'(10);

  logic [NPINS-1:0] dir, flag, mask_a, mask_b, pol, sens, any_edge;
  logic [NPINS-1:0] sync1, sync2, adj_q;
  logic [NPINS-1:0] adj, det, clr_w, set_w;

  function automatic logic hit(input logic [AW-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign adj   = sync2 ^ pol;
  assign det   = ~dir & ((~sens & adj)
                       | (sens & ~any_edge & adj & ~adj_q)
                       | (sens & any_edge & (adj ^ adj_q)));
  assign clr_w = hit(A_FCLR) ? wr_data : '0;
  assign set_w = hit(A_FSET) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0; flag <= '0; mask_a <= '0; mask_b <= '0;
      pol <= '0; sens <= '0; any_edge <= '0;
      sync1 <= '0; sync2 <= '0; adj_q <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      adj_q <= adj;
      flag  <= (flag & ~clr_w) | set_w | det;
      if (hit(A_DIR) || hit(A_DIR2)) dir <= wr_data;
      if (hit(A_MACLR)) mask_a <= mask_a & ~wr_data;
      if (hit(A_MASET)) mask_a <= mask_a | wr_data;
      if (hit(A_MBCLR)) mask_b <= mask_b & ~wr_data;
      if (hit(A_MBSET)) mask_b <= mask_b | wr_data;
      if (hit(A_POL))   pol <= wr_data;
      if (hit(A_SENS))  sens <= wr_data;
      if (hit(A_ANY))   any_edge <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DIR, A_DIR2:     rd_data = dir;
      A_FCLR, A_FSET:    rd_data = flag;
      A_MACLR, A_MASET:  rd_data = mask_a;
      A_MBCLR, A_MBSET:  rd_data = mask_b;
      A_POL:             rd_data = pol;
      A_SENS:            rd_data = sens;
      A_ANY:             rd_data = any_edge;
      default:           rd_data = '0;
    endcase
  end

  assign pin_out = flag;
  assign pin_oe  = dir;
  assign irq_a   = |(flag & mask_a);
  assign irq_b   = |(flag & mask_b);

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_DIR || wr_addr == A_DIR2)) |=> (pin_oe == $past(wr_data)));

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FSET) |=> ((pin_out & $past(wr_data)) == $past(wr_data)));

  assert_clear_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FCLR) |=> ((pin_out & $past(wr_data & pin_oe)) == '0));

  assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((pin_out & pin_oe) == $past(pin_out & pin_oe)));

  assert_irq_a_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !wr_en) |=> irq_a);

  assert_irq_b_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b && !wr_en) |=> irq_b);

endmodule

// File: tb/flag_port_test.sv
module flag_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [3:0] wr_addr;
  logic [N-1:0] wr_data;
  logic [3:0] rd_addr;
  logic [N-1:0] rd_data, pin_in, pin_out, pin_oe;
  logic irq_a, irq_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_port #(.NPINS(N), .AW(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; pin_in = '0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);

    // R1 reset state
    for (int a = 0; a < 11; a++) rd_chk("R1 reset readback", 4'(a), 0);
    check("R1 pin_oe", int'(pin_oe), 0);
    check("R1 irq_a", int'(irq_a), 0);
    check("R1 irq_b", int'(irq_b), 0);
    rd_chk("R2 unmapped read", 4'd15, 0);

    // R3 direction and alias
    wr(4'd0, 4'h5);
    rd_chk("R3 alias read", 4'd1, 5);
    check("R3 pin_oe", int'(pin_oe), 5);
    wr(4'd1, 4'hA);
    rd_chk("R3 alias write", 4'd0, 'hA);
    check("R3 pin_oe alias", int'(pin_oe), 'hA);

    // R2 config readback
    wr(4'd0, 4'hF);
    wr(4'd8, 4'h3);  rd_chk("R2 polarity read", 4'd8, 3);
    wr(4'd9, 4'h6);  rd_chk("R2 sensitivity read", 4'd9, 6);
    wr(4'd10, 4'h9); rd_chk("R2 any-edge read", 4'd10, 9);
    wr(4'd8, 4'h0); wr(4'd9, 4'h0); wr(4'd10, 4'h0);

    // R4 set/clear sweep on outputs
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 16; c++) begin
        wr(4'd2, 4'hF);
        wr(4'd3, 4'(v));
        rd_chk("R4 set", 4'd3, v);
        check("R4 pin_out after set", int'(pin_out), v);
        wr(4'd2, 4'(c));
        rd_chk("R4 clear", 4'd2, v & ~c & 'hF);
        check("R4 pin_out after clear", int'(pin_out), v & ~c & 'hF);
      end
    end

    // R5 clear on inputs (edge mode, quiet pins)
    wr(4'd0, 4'h0);
    wr(4'd9, 4'hF);
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 16; c++) begin
        wr(4'd2, 4'hF);
        wr(4'd3, 4'(v));
        wr(4'd2, 4'(c));
        rd_chk("R5 clear on input", 4'd2, v & ~c & 'hF);
      end
    end

    // R6 outputs ignore pins
    wr(4'd9, 4'h0);
    wr(4'd0, 4'hF);
    wr(4'd2, 4'hF);
    wr(4'd3, 4'h5);
    pin_in = 4'hF; waitc(5);
    rd_chk("R6 output ignores high pin", 4'd3, 5);
    pin_in = 4'h0; waitc(5);
    rd_chk("R6 output ignores low pin", 4'd3, 5);

    // R7 synchronizer latency
    wr(4'd0, 4'h0);
    waitc(4);
    wr(4'd2, 4'hF);
    pin_in = 4'h1;
    waitc(1); rd_chk("R7 after edge 1", 4'd2, 0);
    waitc(1); rd_chk("R7 after edge 2", 4'd2, 0);
    waitc(1); rd_chk("R7 after edge 3", 4'd2, 1);

    // R8 level mode stickiness
    wr(4'd2, 4'h1);
    rd_chk("R8 clear while active", 4'd2, 1);
    pin_in = 4'h0; waitc(4);
    rd_chk("R8 sticky after inactive", 4'd2, 1);
    wr(4'd2, 4'h1);
    rd_chk("R8 clear when inactive", 4'd2, 0);

    // R9 edge mode
    wr(4'd9, 4'hF);
    waitc(2);
    wr(4'd2, 4'hF);
    for (int p = 1; p < 16; p++) begin
      pin_in = 4'(p); waitc(4);
      rd_chk("R9 rising sets", 4'd2, p);
      wr(4'd2, 4'hF);
      pin_in = 4'h0; waitc(4);
      rd_chk("R9 falling ignored", 4'd2, 0);
    end
    wr(4'd8, 4'hF);
    waitc(2);
    wr(4'd2, 4'hF);
    pin_in = 4'hF; waitc(4);
    rd_chk("R9 inverted falling adj ignored", 4'd2, 0);
    pin_in = 4'h0; waitc(4);
    rd_chk("R9 inverted falling pin sets", 4'd2, 'hF);
    wr(4'd8, 4'h0);
    waitc(2);
    wr(4'd2, 4'hF);

    // R10 any-edge mode
    wr(4'd10, 4'hF);
    for (int p = 1; p < 16; p++) begin
      pin_in = 4'(p); waitc(4);
      rd_chk("R10 rising sets", 4'd2, p);
      wr(4'd2, 4'hF);
      pin_in = 4'h0; waitc(4);
      rd_chk("R10 falling sets", 4'd2, p);
      wr(4'd2, 4'hF);
    end

    // R11 narrow pulses in level mode
    wr(4'd9, 4'h0); wr(4'd10, 4'h0); wr(4'd8, 4'h0);
    waitc(4);
    wr(4'd2, 4'hF);
    rd_chk("R11 idle low", 4'd2, 0);
    pin_in = 4'hF; waitc(1); pin_in = 4'h0;
    waitc(5);
    rd_chk("R11 high pulse caught pol 0", 4'd2, 'hF);
    pin_in = 4'hF; waitc(4);
    wr(4'd8, 4'hF);
    wr(4'd2, 4'hF);
    waitc(2);
    rd_chk("R11 idle high pol 1", 4'd2, 0);
    pin_in = 4'h0; waitc(1); pin_in = 4'hF;
    waitc(5);
    rd_chk("R11 low pulse caught pol 1", 4'd2, 'hF);

    // R12 interrupt sweep on outputs
    wr(4'd0, 4'hF);
    wr(4'd8, 4'h0);
    for (int f = 0; f < 16; f++) begin
      for (int m = 0; m < 16; m++) begin
        wr(4'd2, 4'hF);
        wr(4'd3, 4'(f));
        wr(4'd4, 4'hF);
        wr(4'd5, 4'(m));
        wr(4'd6, 4'hF);
        wr(4'd7, 4'(~m));
        check("R12 irq_a", int'(irq_a), int'((f & m) != 0));
        check("R12 irq_b", int'(irq_b), int'((f & ~m & 'hF) != 0));
        rd_chk("R12 mask A read", 4'd4, m);
        rd_chk("R12 mask B read", 4'd7, ~m & 'hF);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule